// File: doc/BRIEF.md
# Self-Clearing Board Reset Pulse Register

This block drives six independent active-low reset lines to devices on a board: two processors, a switch MAC, a PHY group, a single PHY and a power-over-Ethernet controller. Host software reaches it through a plain register port with an address, a write strobe, write data and combinational read data. In the full system an I2C target sits in front of this port.

One control register is decoded at offset 0x10. To request a reset, software writes a 0 to the bit that belongs to a device. That device's reset line goes low for a fixed pulse length. The line then releases without any further write, and the bit reads 1 again. Every line has its own timer, so pulses may overlap and each one ends on its own schedule.

The default pulse length is 100 ms at the configured clock frequency. A parameter can override it with a short cycle count for simulation.

Top module: `board_reset_pulse_reg`

## Requirements
- R1: After synchronous reset, every reset output is high and a read of address 0x10 returns 8'hD7.
- R2: A write to address 0x10 that holds 0 in a mapped bit drives the matching output low from the clock edge that samples the write.
- R3: A started pulse holds its output low for exactly PULSE_CYCLES clock cycles. The output then returns high without any host action.
- R4: Writing 1 to a mapped bit has no effect. It neither starts a pulse nor ends one early.
- R5: Writing 0 again to a bit whose pulse is running restarts that bit's timer. The output stays low for PULSE_CYCLES cycles counted from the latest write.
- R6: Pulses on different outputs run at the same time, and each ends independently of the others.
- R7: Reading address 0x10 returns, in every mapped bit, the current level of its output (1 means out of reset). Bits 3 and 5 always read 0.
- R8: Any address other than 0x10 reads 0, and writes to it change no output.
- R9: Output lanes 0 to 5 map to register bits 0, 1, 2, 4, 6 and 7 in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| dev_rst_n | output | 6 | Active-low reset outputs, one per lane |

## Verification
The bench goes after these corner cases:

- **Restarting a running pulse.** A design that ignores the second write releases the line about ten cycles too early.
- **Writing 1 into a running pulse.** A design that treats 1 as a deassert cuts the pulse short.
- **Overlapping pulses on three lanes.** A design with a shared timer ends all three at the same moment.
- **A zero written to another address, and zeros in bits 3 and 5.** Loose address or bit decode would start resets across the board.
- **Exact pulse length.** An off-by-one counter shows up as a one-cycle mismatch at the release edge.

// File: rtl/rstp_pkg.sv
// Shared constants for the reset pulse register.
// Assumes a fixed set of six lanes with a fixed bit placement in the control byte.
package rstp_pkg;
    localparam int NUM_LANES = 6;

    // Register bit that controls a given lane.
    function automatic int lane_bit(input int lane);
        case (lane)
            0:       lane_bit = 0;
            1:       lane_bit = 1;
            2:       lane_bit = 2;
            3:       lane_bit = 4;
            4:       lane_bit = 6;
            default: lane_bit = 7;
        endcase
    endfunction
endpackage

// File: rtl/rstp_decode.sv
// Address decode and per-lane trigger generation.
// Assumes reg_wr is a single-cycle strobe. A lane triggers when its bit is written as 0.
module rstp_decode
    import rstp_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic                 hit,
    output logic [NUM_LANES-1:0] trig
);
    // Address match for the control register.
    always_comb hit = (reg_addr == CTRL_ADDR);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_trig
        localparam int BP = lane_bit(i);
        // Start request: a write hitting the register with this lane's bit at 0.
        always_comb trig[i] = hit && reg_wr && !reg_wdata[BP];
    end

    // Writes elsewhere never trigger a lane.
    assert_foreign_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != CTRL_ADDR) |-> (trig == '0));
    // A write of all ones never triggers a lane.
    assert_ones_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata == '1) |-> (trig == '0));
endmodule

// File: rtl/rstp_timer.sv
// One lane's pulse timer. A trigger loads the full pulse count, and the lane
// stays active until the count runs out. Assumes PULSE_CYCLES >= 2.
module rstp_timer #(
    parameter int PULSE_CYCLES = 5_000_000,
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES - 1);

    logic [CNT_W-1:0] count;

    // Load on trigger (also restarts a running pulse), otherwise count down and release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            count  <= '0;
        end else if (trig) begin
            active <= 1'b1;
            count  <= LOAD;
        end else if (active) begin
            if (count == '0) active <= 1'b0;
            else             count  <= count - 1'b1;
        end
    end

    // A trigger asserts the lane on the next cycle.
    assert_trig_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> active);
    // A trigger reloads the full count, including during a running pulse.
    assert_trig_reloads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (count == LOAD));
    // An idle lane never starts by itself.
    assert_no_self_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !trig) |=> !active);
    // A running pulse with count left is never cut short.
    assert_no_early_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && count != '0) |=> active);
endmodule

// File: rtl/rstp_readback.sv
// Read data mux. Mapped bits show the output level; every other bit and every
// other address reads zero.
module rstp_readback
    import rstp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic [NUM_LANES-1:0] active,
    output logic [DATA_W-1:0]    rdata
);
    // Assemble the readback byte from the lane states.
    always_comb begin
        rdata = '0;
        if (hit) begin
            for (int i = 0; i < NUM_LANES; i++) rdata[lane_bit(i)] = ~active[i];
        end
    end

    // The unused bits 3 and 5 always read zero.
    assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[3] == 1'b0) && (rdata[5] == 1'b0));
endmodule

// File: rtl/board_reset_pulse_reg.sv
// Top of the self-clearing reset pulse register.
// Writing 0 to a mapped bit at CTRL_ADDR pulses that lane's active-low reset
// for PULSE_CYCLES clocks. Assumes a single clock and synchronous reset.
module board_reset_pulse_reg
    import rstp_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int PULSE_MS     = 100,
    parameter int PULSE_CYCLES = (CLK_HZ / 1000) * PULSE_MS,
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [NUM_LANES-1:0] dev_rst_n
);
    logic                 hit;
    logic [NUM_LANES-1:0] trig;
    logic [NUM_LANES-1:0] active;

    rstp_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_decode (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .hit(hit), .trig(trig)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        rstp_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
            .clk(clk), .rst_n(rst_n), .trig(trig[i]), .active(active[i])
        );
        // Drive the active-low pin from the lane state.
        always_comb dev_rst_n[i] = ~active[i];

        // Readback at the control address matches the pin level.
        assert_readback_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
            hit |-> (reg_rdata[lane_bit(i)] == dev_rst_n[i]));
    end

    rstp_readback #(.DATA_W(DATA_W)) u_readback (
        .clk(clk), .rst_n(rst_n), .hit(hit), .active(active), .rdata(reg_rdata)
    );

    // Other addresses read zero.
    assert_foreign_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (reg_rdata == '0));
endmodule

// File: tb/sim_board_reset_pulse_reg.sv
module sim_board_reset_pulse_reg;
    localparam int CLK_PERIOD = 10;
    localparam int P = 20;
    localparam int LB[6] = '{0, 1, 2, 4, 6, 7};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'hFF;
    logic [7:0] reg_rdata;
    logic [5:0] dev_rst_n;

    int checks = 0;
    int fails = 0;
    int rem[6] = '{0, 0, 0, 0, 0, 0};
    logic [5:0] expq[$];

    board_reset_pulse_reg #(.PULSE_CYCLES(P)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_rst_n(dev_rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver-side model: at every edge, compute the expected pins from the requirements and queue them.
    always @(posedge clk) begin
        logic [5:0] e;
        for (int i = 0; i < 6; i++) begin
            if (!rst_n) rem[i] = 0;
            else if (reg_wr && reg_addr == 8'h10 && !reg_wdata[LB[i]]) rem[i] = P;
            else if (rem[i] > 0) rem[i] = rem[i] - 1;
            e[i] = (rem[i] == 0);
        end
        expq.push_back(e);
    end

    // Monitor: pop the expected pins and compare them away from the edge (R2 R3 R4 R5 R6 R8 R9).
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            logic [5:0] e;
            e = expq.pop_front();
            checks++;
            if (dev_rst_n !== e) begin
                fails++;
                $display("FAIL R2 R3 R5 R6 pins at %0t: actual %b expected %b", $time, dev_rst_n, e);
            end
        end
    end

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s read 0x%02h: actual 0x%02h expected 0x%02h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        do_read(8'h10, 8'hD7, "R1");
        // R2 R7: lane 0 pulse visible in readback, other address reads 0 (R8).
        do_write(8'h10, 8'hFE);
        idle(5);
        do_read(8'h10, 8'hD6, "R7");
        do_read(8'h00, 8'h00, "R8");
        idle(22);
        // R4: all-ones write starts nothing.
        do_write(8'h10, 8'hFF);
        idle(5);
        do_read(8'h10, 8'hD7, "R4");
        // R4: writing 1 during a running pulse does not end it.
        do_write(8'h10, 8'hFD);
        idle(3);
        do_write(8'h10, 8'hFF);
        do_read(8'h10, 8'hD5, "R4");
        idle(25);
        // R5: rewriting 0 restarts lane 5.
        do_write(8'h10, 8'h7F);
        idle(10);
        do_write(8'h10, 8'h7F);
        idle(15);
        do_read(8'h10, 8'h57, "R5");
        idle(25);
        // R6: overlapping pulses on lanes 2, 3 and 4 end on their own.
        do_write(8'h10, 8'hEB);
        idle(5);
        do_write(8'h10, 8'hBF);
        idle(5);
        do_read(8'h10, 8'h83, "R6");
        idle(12);
        do_read(8'h10, 8'h97, "R6");
        idle(20);
        // R8 R7: zeros in bits 3 and 5 and writes to another address change nothing.
        do_write(8'h10, 8'hD7);
        do_write(8'h11, 8'h00);
        idle(3);
        do_read(8'h10, 8'hD7, "R7");
        do_read(8'h11, 8'h00, "R8");
        // R9: bit 4 drives lane 3.
        do_write(8'h10, 8'hEF);
        idle(2);
        checks++;
        if (dev_rst_n !== 6'b110111) begin
            fails++;
            $display("FAIL R9 lane map: actual %b expected %b", dev_rst_n, 6'b110111);
        end
        idle(25);
        // R3: everything released by itself.
        do_read(8'h10, 8'hD7, "R3");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule